// File: doc/BRIEF.md
# Four-State Logic and Arithmetic Evaluator

This block evaluates one operation on two operands that carry unknown and high-impedance bits. Each operand arrives as a pair of equal-width vectors: a value vector and a mask vector. A mask bit of 0 marks a known bit, whose value bit is the logic level. A mask bit of 1 marks an uncertain bit. With the mask bit set, a value bit of 1 means X (unknown) and a value bit of 0 means Z (high impedance). A four-bit opcode picks the operation: bitwise AND, OR or XOR, a logical left or right shift of operand A by the amount in operand B, unsigned add, subtract or multiply, or one of four unsigned compares.

The unit tracks how uncertainty spreads through each operation. For AND and OR, a known dominant bit on either side forces a known result bit. XOR keeps every uncertain bit uncertain. Arithmetic and compares are poisoned as a whole once any operand bit is uncertain. A shift by a known amount moves the mask together with the value. A shift by an uncertain amount gives an all-X result. The result is registered: a request presented with its valid strobe appears on the outputs one clock later, and the outputs hold between requests.

Top module: `fourstate_alu`

## Requirements
- R1: While reset is asserted (rst_n low) and on the first cycle after it, out_valid is 0 and both result vectors are all zeros.
- R2: out_valid equals in_valid delayed by one clock. The result of a request sampled at one rising edge is on r_val/r_msk after that edge. When in_valid is low, r_val and r_msk keep their previous contents.
- R3: AND (op 0): a result bit is known 0 when either input bit is known 0 (mask 0, value 0). Otherwise it is X (mask 1, value 1) when either input bit is uncertain, and known 1 when both inputs are known 1.
- R4: OR (op 1): a result bit is known 1 when either input bit is known 1 (mask 0, value 1). Otherwise it is X when either input bit is uncertain, and known 0 when both inputs are known 0.
- R5: XOR (op 2): the result mask is a_msk | b_msk. Uncertain result bits are X. Known bits hold a_val ^ b_val.
- R6: Shifts with every b_msk bit 0: SHL (op 3) and SHR (op 4) move operand A by b_val positions, mask and value together, so Z and X bits keep their encoding. Vacated positions are known 0. An amount of WIDTH or more gives all known 0.
- R7: Shifts with any b_msk bit set give all-X: every mask and value bit is 1.
- R8: ADD (op 5), SUB (op 6) and MUL (op 7) return the unsigned result modulo 2^WIDTH when both masks are zero. If any mask bit of either operand is set, the result is all-X.
- R9: Compares EQ (8), NE (9), LT (10) and GT (11) are unsigned. The outcome is in bit 0 and all other bits are known 0. Bit 0 is X when any operand mask bit is set.
- R10: Opcodes 12 to 15 give an all-X result.
- R11: For the bitwise operations (R3 to R5), the result never carries Z: no bit has mask 1 and value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation select |
| a_val | input | WIDTH | Operand A value bits |
| a_msk | input | WIDTH | Operand A mask bits |
| b_val | input | WIDTH | Operand B value bits (also the shift amount) |
| b_msk | input | WIDTH | Operand B mask bits |
| out_valid | output | 1 | Result strobe |
| r_val | output | WIDTH | Result value bits |
| r_msk | output | WIDTH | Result mask bits |

## Verification
Every result is due exactly one clock after its request is sampled. That is the only register between the operand ports and the result ports. The bench drives a request on a falling edge and computes the expected pair at the same moment, using a per-bit three-state reference. It then compares all outputs 2 ns after the next rising edge, so every comparison lands in the cycle the registered result first appears. During idle cycles the bench expects the previous result to stay put and out_valid to be low. This checks the hold behaviour cycle by cycle.

// File: rtl/fs_pkg.sv
// Package: shared opcode encoding for the four-state evaluator.
// Assumes the opcode field is four bits wide; codes 12..15 are unassigned.
package fs_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_OR  = 4'd1,
        OP_XOR = 4'd2,
        OP_SHL = 4'd3,
        OP_SHR = 4'd4,
        OP_ADD = 4'd5,
        OP_SUB = 4'd6,
        OP_MUL = 4'd7,
        OP_EQ  = 4'd8,
        OP_NE  = 4'd9,
        OP_LT  = 4'd10,
        OP_GT  = 4'd11
    } fs_op_e;

    // Operation classes used by the result select in the top module
    typedef enum logic [1:0] {
        CLS_BIT   = 2'd0,
        CLS_SHIFT = 2'd1,
        CLS_ARITH = 2'd2,
        CLS_BAD   = 2'd3
    } fs_cls_e;

    // Map an opcode to the unit that evaluates it
    function automatic fs_cls_e op_class(input logic [3:0] code);
        if (code <= 4'd2)       return CLS_BIT;
        else if (code <= 4'd4)  return CLS_SHIFT;
        else if (code <= 4'd11) return CLS_ARITH;
        else                    return CLS_BAD;
    endfunction

endpackage

// File: rtl/fs_bitwise.sv
// Module: per-bit four-state AND / OR / XOR.
// Each result bit depends only on the matching operand bits. Uncertain
// result bits come out as X (value forced to 1), never as Z.
// Assumes sel holds 0 (AND), 1 (OR) or 2 (XOR); other codes return XOR.
module fs_bitwise #(
    parameter int W = 16
) (
    input  logic [1:0]   sel,
    input  logic [W-1:0] av,
    input  logic [W-1:0] am,
    input  logic [W-1:0] bv,
    input  logic [W-1:0] bm,
    output logic [W-1:0] rv,
    output logic [W-1:0] rm
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic a_k0, a_k1, b_k0, b_k1, any_u;
        logic m_and, m_or, m_xor;

        // Per-bit classification of each operand bit
        always_comb begin
            a_k0  = ~am[i] & ~av[i];
            a_k1  = ~am[i] &  av[i];
            b_k0  = ~bm[i] & ~bv[i];
            b_k1  = ~bm[i] &  bv[i];
            any_u = am[i] | bm[i];
        end

        // Mask of each operation: a dominant known bit clears uncertainty
        always_comb begin
            m_and = any_u & ~a_k0 & ~b_k0;
            m_or  = any_u & ~a_k1 & ~b_k1;
            m_xor = any_u;
        end

        // Select the operation and build the value bit (X when masked)
        always_comb begin
            unique case (sel)
                2'd0: begin
                    rm[i] = m_and;
                    rv[i] = m_and | (av[i] & bv[i]);
                end
                2'd1: begin
                    rm[i] = m_or;
                    rv[i] = m_or | (~a_k0 & ~b_k0 & ~any_u) | a_k1 | b_k1;
                end
                default: begin
                    rm[i] = m_xor;
                    rv[i] = m_xor | (av[i] ^ bv[i]);
                end
            endcase
        end
    end

endmodule

// File: rtl/fs_shifter.sv
// Module: logical shift of a four-state operand by a known amount.
// The value and mask move together through a logarithmic stage chain,
// so Z and X bits keep their encoding; vacated bits are known 0.
// An amount of W or more clears the result. An uncertain amount is
// handled by the caller (all-X); this module only sees the value bits.
module fs_shifter #(
    parameter int W = 16
) (
    input  logic         left,
    input  logic [W-1:0] av,
    input  logic [W-1:0] am,
    input  logic [W-1:0] amt,
    output logic [W-1:0] rv,
    output logic [W-1:0] rm
);

    localparam int SW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0] sv [SW+1];
    logic [W-1:0] sm [SW+1];
    logic         too_far;

    // Amounts at or above the width push every bit out
    always_comb too_far = ({1'b0, amt} >= (W+1)'(W));

    assign sv[0] = av;
    assign sm[0] = am;

    // Stage k shifts by 2**k when amount bit k is set
    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int D = 1 << k;
        always_comb begin
            if (!amt[k]) begin
                sv[k+1] = sv[k];
                sm[k+1] = sm[k];
            end else if (left) begin
                sv[k+1] = sv[k] << D;
                sm[k+1] = sm[k] << D;
            end else begin
                sv[k+1] = sv[k] >> D;
                sm[k+1] = sm[k] >> D;
            end
        end
    end

    // Final stage output, cleared for out-of-range amounts
    always_comb begin
        rv = too_far ? '0 : sv[SW];
        rm = too_far ? '0 : sm[SW];
    end

endmodule

// File: rtl/fs_arith.sv
// Module: unsigned add, subtract, multiply and compare on four-state
// operands. Any uncertain operand bit poisons the whole result to X
// (compares: bit 0 only, upper bits stay known 0).
// Assumes code is one of OP_ADD..OP_GT.
module fs_arith #(
    parameter int W = 16
) (
    input  logic [3:0]   code,
    input  logic [W-1:0] av,
    input  logic [W-1:0] am,
    input  logic [W-1:0] bv,
    input  logic [W-1:0] bm,
    output logic [W-1:0] rv,
    output logic [W-1:0] rm
);
    import fs_pkg::*;

    logic         unk;
    logic [W-1:0] sum, dif, prd;
    logic         flag;
    logic         is_cmp;

    // Any uncertain bit anywhere in either operand
    always_comb unk = (|am) | (|bm);

    // Two-state datapath results, truncated to W bits
    always_comb begin
        sum = av + bv;
        dif = av - bv;
        prd = W'(av * bv);
    end

    // Compare outcome for the selected predicate
    always_comb begin
        is_cmp = 1'b1;
        flag   = 1'b0;
        case (code)
            OP_EQ:   flag = (av == bv);
            OP_NE:   flag = (av != bv);
            OP_LT:   flag = (av <  bv);
            OP_GT:   flag = (av >  bv);
            default: is_cmp = 1'b0;
        endcase
    end

    // Assemble the value/mask pair with poisoning applied
    always_comb begin
        if (is_cmp) begin
            rv    = '0;
            rm    = '0;
            rv[0] = unk | flag;
            rm[0] = unk;
        end else if (unk) begin
            rv = '1;
            rm = '1;
        end else begin
            rm = '0;
            case (code)
                OP_ADD:  rv = sum;
                OP_SUB:  rv = dif;
                default: rv = prd;
            endcase
        end
    end

endmodule

// File: rtl/fourstate_alu.sv
// Module: top of the four-state evaluator. Routes the request to the
// bitwise, shift or arithmetic unit, applies the all-X rules for an
// uncertain shift amount and for unassigned opcodes, and registers the
// selected value/mask pair. One clock of latency; the outputs hold while
// in_valid is low. Synchronous active-low reset.
module fourstate_alu #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] a_val,
    input  logic [WIDTH-1:0] a_msk,
    input  logic [WIDTH-1:0] b_val,
    input  logic [WIDTH-1:0] b_msk,
    output logic             out_valid,
    output logic [WIDTH-1:0] r_val,
    output logic [WIDTH-1:0] r_msk
);
    import fs_pkg::*;

    fs_cls_e          cls;
    logic [WIDTH-1:0] bw_v, bw_m, sh_v, sh_m, ar_v, ar_m;
    logic [WIDTH-1:0] nx_v, nx_m;

    // Decode the operation class
    always_comb cls = op_class(op);

    fs_bitwise #(.W(WIDTH)) u_bit (
        .sel (op[1:0]),
        .av  (a_val), .am (a_msk),
        .bv  (b_val), .bm (b_msk),
        .rv  (bw_v),  .rm (bw_m)
    );

    fs_shifter #(.W(WIDTH)) u_shf (
        .left (op == OP_SHL),
        .av   (a_val), .am (a_msk),
        .amt  (b_val),
        .rv   (sh_v),  .rm (sh_m)
    );

    fs_arith #(.W(WIDTH)) u_ari (
        .code (op),
        .av   (a_val), .am (a_msk),
        .bv   (b_val), .bm (b_msk),
        .rv   (ar_v),  .rm (ar_m)
    );

    // Pick the unit output; uncertain shift amounts and bad codes give X
    always_comb begin
        unique case (cls)
            CLS_BIT: begin
                nx_v = bw_v;
                nx_m = bw_m;
            end
            CLS_SHIFT: begin
                nx_v = (|b_msk) ? '1 : sh_v;
                nx_m = (|b_msk) ? '1 : sh_m;
            end
            CLS_ARITH: begin
                nx_v = ar_v;
                nx_m = ar_m;
            end
            default: begin
                nx_v = '1;
                nx_m = '1;
            end
        endcase
    end

    // Result register: cleared in reset, loaded only on a valid request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            r_val     <= '0;
            r_msk     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                r_val <= nx_v;
                r_msk <= nx_m;
            end
        end
    end

endmodule

// File: rtl/fs_alu_chk.sv
// Checker: temporal properties of the evaluator's port behaviour.
// Bound to every fourstate_alu instance.
module fs_alu_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [3:0]       op,
    input logic [WIDTH-1:0] a_msk,
    input logic [WIDTH-1:0] b_msk,
    input logic             out_valid,
    input logic [WIDTH-1:0] r_val,
    input logic [WIDTH-1:0] r_msk
);

    // R2: the strobe follows the request by one clock
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2: the result holds while no request is presented
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(r_val) && $stable(r_msk)));

    // R5: the XOR mask is the union of the input masks
    a_r5_xor_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd2) |=> (r_msk == ($past(a_msk) | $past(b_msk))));

    // R7: an uncertain shift amount poisons every bit
    a_r7_shift_unknown: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 4'd3 || op == 4'd4) && (|b_msk))
        |=> ((&r_msk) && (&r_val)));

    // R8: an uncertain arithmetic operand poisons every bit
    a_r8_arith_poison: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= 4'd5 && op <= 4'd7 && ((|a_msk) || (|b_msk)))
        |=> ((&r_msk) && (&r_val)));

    // R9: compare results occupy bit 0 only
    a_r9_cmp_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= 4'd8 && op <= 4'd11)
        |=> ((r_msk >> 1) == '0 && (r_val >> 1) == '0));

    // R10: unassigned opcodes give all-X
    a_r10_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= 4'd12) |=> ((&r_msk) && (&r_val)));

    // R11: bitwise results never carry Z
    a_r11_no_z: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op <= 4'd2) |=> ((r_msk & ~r_val) == '0));

endmodule

bind fourstate_alu fs_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .a_msk     (a_msk),
    .b_msk     (b_msk),
    .out_valid (out_valid),
    .r_val     (r_val),
    .r_msk     (r_msk)
);

// File: tb/fourstate_alu_bench.sv
// Bench: drives requests on falling edges, predicts each result with a
// behavioural per-bit three-state model, compares 2 ns after each rise.
module fourstate_alu_bench;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   op = '0;
    logic [W-1:0] a_val = '0, a_msk = '0, b_val = '0, b_msk = '0;
    logic         out_valid;
    logic [W-1:0] r_val, r_msk;

    int n_chk = 0;
    int n_bad = 0;
    bit checking = 1'b0;
    bit done = 1'b0;

    // Expected outputs for the next comparison
    logic         e_valid = 1'b0;
    logic [W-1:0] e_val = '0, e_msk = '0;
    string        e_req = "R1";

    always #5 clk = ~clk;

    fourstate_alu #(.WIDTH(W)) u_fourstate_alu (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .op (op),
        .a_val (a_val), .a_msk (a_msk), .b_val (b_val), .b_msk (b_msk),
        .out_valid (out_valid), .r_val (r_val), .r_msk (r_msk)
    );

    function automatic string req_of(input int code);
        case (code)
            0: return "R3";   1: return "R4";   2: return "R5";
            3, 4: return "R6";
            5, 6, 7: return "R8";
            8, 9, 10, 11: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Reference model: state per bit 0, 1 or 2 (= uncertain)
    task automatic model(input int code, input logic [W-1:0] av, am, bv, bm,
                         output logic [W-1:0] rv, rm);
        int  a, b, amt;
        bit  unk;
        unk = (am != 0) || (bm != 0);
        a = av; b = bv;
        rv = '0; rm = '0;
        if (code <= 2) begin
            for (int i = 0; i < W; i++) begin
                int sa, sb, s;
                sa = am[i] ? 2 : int'(av[i]);
                sb = bm[i] ? 2 : int'(bv[i]);
                if (code == 0)
                    s = (sa == 0 || sb == 0) ? 0 : ((sa == 2 || sb == 2) ? 2 : 1);
                else if (code == 1)
                    s = (sa == 1 || sb == 1) ? 1 : ((sa == 2 || sb == 2) ? 2 : 0);
                else
                    s = (sa == 2 || sb == 2) ? 2 : (sa ^ sb);
                rm[i] = (s == 2);
                rv[i] = (s != 0);
            end
        end else if (code <= 4) begin
            if (bm != 0) begin
                rv = '1; rm = '1;
            end else begin
                amt = b;
                for (int i = 0; i < W; i++) begin
                    int src;
                    src = (code == 3) ? i - amt : i + amt;
                    if (src >= 0 && src < W) begin
                        rv[i] = av[src]; rm[i] = am[src];
                    end
                end
            end
        end else if (code <= 7) begin
            if (unk) begin
                rv = '1; rm = '1;
            end else begin
                int t;
                t = (code == 5) ? a + b : (code == 6) ? a - b + (1 << W) : a * b;
                rv = W'(t % (1 << W));
            end
        end else if (code <= 11) begin
            bit f;
            f = (code == 8) ? (a == b) : (code == 9) ? (a != b) :
                (code == 10) ? (a < b) : (a > b);
            rm[0] = unk;
            rv[0] = unk | f;
        end else begin
            rv = '1; rm = '1;
        end
    endtask

    // Present one request and record the expected result
    task automatic drive(input int code, input logic [W-1:0] av, am, bv, bm);
        logic [W-1:0] xv, xm;
        @(negedge clk);
        model(code, av, am, bv, bm, xv, xm);
        in_valid = 1'b1; op = 4'(code);
        a_val = av; a_msk = am; b_val = bv; b_msk = bm;
        e_valid = 1'b1; e_val = xv; e_msk = xm; e_req = req_of(code);
    endtask

    // One idle cycle: outputs must hold (R2)
    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        a_val = ~a_val; b_msk = ~b_msk; op = op + 4'd1;
        e_valid = 1'b0; e_req = "R2";
    endtask

    // Split an 8-bit index into a W-bit pair, two bits per operand bit
    function automatic logic [2*W-1:0] unpack(input int idx);
        logic [W-1:0] v, m;
        for (int i = 0; i < W; i++) begin
            v[i] = idx[2*i];
            m[i] = idx[2*i+1];
        end
        return {m, v};
    endfunction

    // Compare on every clock, 2 ns after the rising edge
    always @(posedge clk) begin
        #2;
        if (checking) begin
            n_chk++;
            if (out_valid !== e_valid || r_val !== e_val || r_msk !== e_msk) begin
                n_bad++;
                $display("FAIL %s: got v=%b val=%b msk=%b, expected v=%b val=%b msk=%b",
                         e_req, out_valid, r_val, r_msk, e_valid, e_val, e_msk);
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2*W-1:0] pa, pb;
        // R1: reset state, during and just after reset
        repeat (3) @(posedge clk);
        #2;
        n_chk++;
        if (out_valid !== 1'b0 || r_val !== '0 || r_msk !== '0) begin
            n_bad++;
            $display("FAIL R1: got v=%b val=%b msk=%b, expected 0 0000 0000",
                     out_valid, r_val, r_msk);
        end
        @(negedge clk);
        rst_n = 1'b1;
        checking = 1'b1;
        idle();
        idle();

        // Mixed four-state sweep of every opcode (R3..R10)
        for (int c = 0; c < 16; c++) begin
            for (int ia = 0; ia < 256; ia++) begin
                for (int j = 0; j < 3; j++) begin
                    pa = unpack(ia);
                    pb = unpack((ia * 53 + j * 97 + c * 11) % 256);
                    drive(c, pa[W-1:0], pa[2*W-1:W], pb[W-1:0], pb[2*W-1:W]);
                end
            end
            idle();   // R2 hold after a burst
        end

        // R6: every operand A state against every known shift amount
        for (int c = 3; c <= 4; c++)
            for (int ia = 0; ia < 256; ia++)
                for (int s = 0; s < 16; s++) begin
                    pa = unpack(ia);
                    drive(c, pa[W-1:0], pa[2*W-1:W], W'(s), '0);
                end

        // R8, R9: exhaustive fully known operands
        for (int c = 5; c <= 11; c++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    drive(c, W'(x), '0, W'(y), '0);

        // R2: a long idle stretch after a valid result
        drive(5, 4'd9, '0, 4'd12, '0);
        repeat (5) idle();

        @(negedge clk);
        checking = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule